// File: doc/BRIEF.md
# Link Self-Test Training Sequencer

This block steps the transmitter of a serial memory channel through a built-in link test. Software sets a start bit. The sequencer then optionally waits for the link running in the opposite direction to finish its own bring-up. After that it spends a programmed number of cycles in a disable state and, if enabled, runs a calibration window during which the line is held at constant one. It then sends a burst of TS0 training sequences followed by a run of TS1 sequences. The TS1 run is either counted or endless.

All counts and switches are plain configuration inputs. They must be held stable while a run is in progress. The outputs are a phase code, a drive-one flag for the serializer, a one-cycle strobe at the start of each training sequence with a kind bit, a device-ID field that is valid during TS0, and a done flag. Each training sequence occupies `SEQ_LEN` cycles (12 by default).

Top module: `link_selftest_seq`

## Requirements
- R1: After reset, and on the clock after `start_en` is low, `phase` is 0 (idle) and `done`, `drive_one` and `seq_start` are 0. From idle, a high `start_en` moves `phase` to 1 (wait) on the next clock.
- R2: `phase` stays at 1 while both `skip_peer_wait` and `peer_init_done` are 0. When either one is 1, the next phase is 2 (disable).
- R3: Phase 2 lasts exactly `dis_cnt` cycles.
- R4: When `cal_en` is 1, phase 3 follows the disable phase and lasts `cal_cnt` cycles, with `drive_one` high on every one of those cycles. When `cal_en` is 0, phase 3 is skipped and `drive_one` stays 0.
- R5: Phase 4 sends `ts0_cnt` sequences of `SEQ_LEN` cycles each. `seq_start` is high on the first cycle of each sequence with `seq_kind`=0 and `seq_id`=`dev_id`.
- R6: With `ts1_cnt[7]`=0, phase 5 sends `ts1_cnt[6:0]` sequences, each strobed with `seq_kind`=1 and `seq_id`=0. The sequencer then enters phase 6 (done).
- R7: With `ts1_cnt[7]`=1, phase 5 repeats sequences without end and `done` never rises.
- R8: A zero count in the disable, TS0 or finite TS1 phase makes that phase last exactly one cycle and produce no `seq_start` strobe.
- R9: In phase 6, `done` is 1 and is held until `start_en` is cleared.
- R10: Clearing `start_en` in any phase returns the sequencer to idle on the next clock and clears all counters, so a later start runs the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Starts the test; clearing it aborts the run |
| skip_peer_wait | input | 1 | 1 = do not wait for the opposite link direction |
| peer_init_done | input | 1 | The opposite link direction has finished initialization |
| cal_en | input | 1 | Enables the calibration phase |
| dis_cnt | input | DIS_W (10) | Number of cycles in the disable phase |
| cal_cnt | input | CAL_W (20) | Number of drive-one cycles during calibration |
| ts0_cnt | input | TS0_W (10) | Number of TS0 sequences |
| ts1_cnt | input | 8 | Number of TS1 sequences; bit 7 set = endless |
| dev_id | input | ID_W (4) | Device ID placed in the TS0 sequences |
| phase | output | 3 | 0 idle, 1 wait, 2 disable, 3 calibrate, 4 TS0, 5 TS1, 6 done |
| drive_one | output | 1 | Drive constant one this cycle |
| seq_start | output | 1 | First cycle of a training sequence |
| seq_kind | output | 1 | 0 = TS0, 1 = TS1 |
| seq_id | output | ID_W (4) | Device ID field; `dev_id` during TS0, otherwise 0 |
| done | output | 1 | A finite run has completed |

## Verification
On every cycle, the assertions check the local rules. An abort must reach idle on the next clock. The wait phase must hold while it is blocked. `drive_one` may rise only when calibration is enabled. Strobes must be isolated pulses. `done` must persist. An endless TS1 run must never leave phase 5. The exact length of each phase, the number of strobes and the ID they carry, and the single-cycle skips on zero counts depend on the full path through the phases. Only the bench's scenarios can show these, by counting cycles per phase against values computed from the configuration.

// File: rtl/link_selftest_seq.sv
module link_selftest_seq #(
  parameter int DIS_W   = 10,
  parameter int CAL_W   = 20,
  parameter int TS0_W   = 10,
  parameter int ID_W    = 4,
  parameter int SEQ_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic             skip_peer_wait,
  input  logic             peer_init_done,
  input  logic             cal_en,
  input  logic [DIS_W-1:0] dis_cnt,
  input  logic [CAL_W-1:0] cal_cnt,
  input  logic [TS0_W-1:0] ts0_cnt,
  input  logic [7:0]       ts1_cnt,
  input  logic [ID_W-1:0]  dev_id,
  output logic [2:0]       phase,
  output logic             drive_one,
  output logic             seq_start,
  output logic             seq_kind,
  output logic [ID_W-1:0]  seq_id,
  output logic             done
);
  localparam int CNT_W = (CAL_W > DIS_W) ? ((CAL_W > TS0_W) ? CAL_W : TS0_W)
                                         : ((DIS_W > TS0_W) ? DIS_W : TS0_W);
  localparam int SUB_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SEQ_LEN - 1);

  typedef enum logic [2:0] {
    P_IDLE = 3'd0, P_WAIT = 3'd1, P_DIS = 3'd2, P_CAL = 3'd3,
    P_TS0 = 3'd4, P_TS1 = 3'd5, P_DONE = 3'd6
  } phase_t;

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub;

  wire [CNT_W-1:0] cnt_nx   = cnt + 1'b1;
  wire             seq_end  = (sub == SUB_LAST);
  wire             dis_last = (cnt_nx >= CNT_W'(dis_cnt));
  wire             cal_last = (cnt_nx >= CNT_W'(cal_cnt));
  wire             ts0_zero = (ts0_cnt == '0);
  wire             ts0_last = (cnt_nx >= CNT_W'(ts0_cnt));
  wire             ts1_inf  = ts1_cnt[7];
  wire             ts1_zero = !ts1_inf && (ts1_cnt[6:0] == 7'd0);
  wire             ts1_last = (cnt_nx >= CNT_W'(ts1_cnt[6:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= P_IDLE;
      cnt <= '0;
      sub <= '0;
    end else if (!start_en) begin
      ph  <= P_IDLE;
      cnt <= '0;
      sub <= '0;
    end else begin
      case (ph)
        P_IDLE: ph <= P_WAIT;
        P_WAIT: if (skip_peer_wait || peer_init_done) ph <= P_DIS;
        P_DIS: begin
          if (dis_last) begin
            ph  <= cal_en ? P_CAL : P_TS0;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        P_CAL: begin
          if (cal_last) begin
            ph  <= P_TS0;
            cnt <= '0;
          end else cnt <= cnt_nx;
        end
        P_TS0: begin
          if (ts0_zero) begin
            ph  <= P_TS1;
            cnt <= '0;
            sub <= '0;
          end else if (seq_end) begin
            sub <= '0;
            if (ts0_last) begin
              ph  <= P_TS1;
              cnt <= '0;
            end else cnt <= cnt_nx;
          end else sub <= sub + 1'b1;
        end
        P_TS1: begin
          if (ts1_zero) begin
            ph  <= P_DONE;
            cnt <= '0;
            sub <= '0;
          end else if (seq_end) begin
            sub <= '0;
            if (!ts1_inf) begin
              if (ts1_last) begin
                ph  <= P_DONE;
                cnt <= '0;
              end else cnt <= cnt_nx;
            end
          end else sub <= sub + 1'b1;
        end
        P_DONE: ph <= P_DONE;
        default: ph <= P_IDLE;
      endcase
    end
  end

  assign phase     = ph;
  assign drive_one = (ph == P_CAL);
  assign seq_start = (sub == '0) &&
                     (((ph == P_TS0) && !ts0_zero) || ((ph == P_TS1) && !ts1_zero));
  assign seq_kind  = (ph == P_TS1);
  assign seq_id    = (ph == P_TS0) ? dev_id : '0;
  assign done      = (ph == P_DONE);

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_en |=> (phase == 3'd0 && !done)); // R10

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_en && phase == 3'd1 && !skip_peer_wait && !peer_init_done) |=> (phase == 3'd1)); // R2

  AST_DRIVE_NEEDS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    drive_one |-> cal_en); // R4

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R5

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start_en) |=> done); // R9

  AST_ENDLESS_TS1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_en && phase == 3'd5 && ts1_cnt[7]) |=> (phase == 3'd5 && !done)); // R7
endmodule

// File: tb/link_selftest_seq_bench.sv
`timescale 1ns/1ps
module link_selftest_seq_bench;
  logic clk = 0, rst_n = 0;
  logic start_en = 0, skip_peer_wait = 1, peer_init_done = 0, cal_en = 0;
  logic [9:0]  dis_cnt = 0;
  logic [19:0] cal_cnt = 0;
  logic [9:0]  ts0_cnt = 0;
  logic [7:0]  ts1_cnt = 0;
  logic [3:0]  dev_id = 0;
  logic [2:0]  phase;
  logic drive_one, seq_start, seq_kind, done;
  logic [3:0] seq_id;

  int total = 0, bad = 0;
  int pc[8];
  int drv, s0, s1, idbad, nsamp;
  logic saw_done;

  always #10 clk = ~clk;

  link_selftest_seq u_link_selftest_seq (
    .clk(clk), .rst_n(rst_n), .start_en(start_en), .skip_peer_wait(skip_peer_wait),
    .peer_init_done(peer_init_done), .cal_en(cal_en), .dis_cnt(dis_cnt),
    .cal_cnt(cal_cnt), .ts0_cnt(ts0_cnt), .ts1_cnt(ts1_cnt), .dev_id(dev_id),
    .phase(phase), .drive_one(drive_one), .seq_start(seq_start),
    .seq_kind(seq_kind), .seq_id(seq_id), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    for (int k = 0; k < 8; k++) pc[k] = 0;
    drv = 0; s0 = 0; s1 = 0; idbad = 0; nsamp = 0; saw_done = 0;
  endtask

  task automatic sample();
    pc[phase]++;
    nsamp++;
    if (drive_one) drv++;
    if (done) saw_done = 1;
    if (seq_start && !seq_kind) begin s0++; if (seq_id != dev_id) idbad++; end
    if (seq_start && seq_kind)  begin s1++; if (seq_id != 4'd0) idbad++; end
  endtask

  task automatic run(input int limit);
    clear_stats();
    start_en = 1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (phase == 3'd6) break;
      sample();
    end
  endtask

  task automatic stop();
    start_en = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset phase", phase, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset strobe/drive", {seq_start, drive_one}, 0);
  endtask

  task automatic t_basic();
    skip_peer_wait = 1; cal_en = 1; dis_cnt = 5; cal_cnt = 7;
    ts0_cnt = 3; ts1_cnt = 2; dev_id = 4'hA;
    run(1000);
    chk("R1 wait cycles", pc[1], 1);
    chk("R3 disable cycles", pc[2], 5);
    chk("R4 cal cycles", pc[3], 7);
    chk("R4 drive_one cycles", drv, 7);
    chk("R5 ts0 cycles", pc[4], 36);
    chk("R5 ts0 strobes", s0, 3);
    chk("R5 R6 id field errors", idbad, 0);
    chk("R6 ts1 cycles", pc[5], 24);
    chk("R6 ts1 strobes", s1, 2);
    chk("R6 reached done phase", phase, 6);
    chk("R9 done flag", done, 1);
    for (int k = 0; k < 10; k++) @(negedge clk);
    chk("R9 done held", {phase, done}, {3'd6, 1'b1});
    stop();
    chk("R9 done cleared", done, 0);
    chk("R1 idle after clear", phase, 0);
  endtask

  task automatic t_zero();
    cal_en = 0; dis_cnt = 0; ts0_cnt = 0; ts1_cnt = 0; dev_id = 4'h3;
    run(100);
    chk("R8 disable one cycle", pc[2], 1);
    chk("R4 no cal phase", pc[3], 0);
    chk("R4 no drive_one", drv, 0);
    chk("R8 ts0 one cycle", pc[4], 1);
    chk("R8 ts1 one cycle", pc[5], 1);
    chk("R8 no strobes", s0 + s1, 0);
    chk("R8 done reached", done, 1);
    stop();
  endtask

  task automatic t_wait();
    skip_peer_wait = 0; peer_init_done = 0; dis_cnt = 2; ts0_cnt = 1; ts1_cnt = 1;
    start_en = 1;
    clear_stats();
    for (int k = 0; k < 20; k++) begin @(negedge clk); sample(); end
    chk("R2 held in wait", pc[1], 20);
    peer_init_done = 1;
    @(negedge clk);
    chk("R2 left wait on peer done", phase, 2);
    stop();
    peer_init_done = 0;
  endtask

  task automatic t_endless();
    skip_peer_wait = 1; cal_en = 0; dis_cnt = 5; ts0_cnt = 3; ts1_cnt = 8'h81;
    clear_stats();
    start_en = 1;
    for (int k = 0; k < 300; k++) begin @(negedge clk); sample(); end
    chk("R7 still in ts1", phase, 5);
    chk("R7 never done", saw_done, 0);
    chk("R7 ts1 strobes", s1, 22);
    stop();
  endtask

  task automatic t_abort();
    skip_peer_wait = 1; cal_en = 1; dis_cnt = 5; cal_cnt = 7;
    ts0_cnt = 3; ts1_cnt = 2; dev_id = 4'h5;
    start_en = 1;
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk("R10 mid-ts0 before abort", phase, 4);
    start_en = 0;
    @(negedge clk);
    chk("R10 idle next clock", phase, 0);
    run(1000);
    chk("R10 restart disable", pc[2], 5);
    chk("R10 restart cal", pc[3], 7);
    chk("R10 restart ts0 strobes", s0, 3);
    chk("R10 restart ts1 strobes", s1, 2);
    chk("R10 restart done", done, 1);
    stop();
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero();
    t_wait();
    t_endless();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule